// File: doc/BRIEF.md
# Dual-Mode Interval Timer with Pulse Output

This block is a 16-bit down-counting interval timer that sits on a byte-wide CPU register bus. Software fills two 8-bit reload latches and starts the timer by writing the high byte of the counter. The counter decrements once for every clock in which the slow count strobe `cnt_en` is high. When it times out, the block sends a single-cycle set pulse to an interrupt flag register that lives outside the block. Bus accesses that acknowledge the timer send a single-cycle clear pulse to the same register.

Two mode inputs set the behaviour. `free_run` chooses between a periodic timer, which reloads itself from the latches, and a one-shot timer, which raises its flag once per start and then keeps counting down through zero without reloading. `out_en` lets the timer drive a pulse output pin. In one-shot mode the pin is held low from the start until the timeout, which gives a single low pulse. In periodic mode the pin toggles at every timeout, which gives a square wave.

Top module: `interval_timer`

## Requirements
- R1: After reset both latches read 0xFF, the timer is not armed, `pulse_out` is 1, and `flag_set` and `flag_clr` are 0.
- R2: A write to offset 4 or offset 6 changes only the low latch. Offset 6 reads the low latch back, and the high latch keeps its value.
- R3: A write to offset 7 changes only the high latch. It produces a `flag_clr` pulse in the following cycle and leaves the counter unchanged.
- R4: A write of byte D to offset 5 sets the high latch to D, loads the counter with {D, low latch}, arms the timer and produces a `flag_clr` pulse.
- R5: In one-shot mode (`free_run`=0), a load of N produces exactly one `flag_set`, in the cycle after the (N+1)th strobe. The counter is then 0xFFFF and keeps decrementing through zero with no reload and no further `flag_set`.
- R6: In periodic mode (`free_run`=1), every timeout produces a `flag_set` and reloads the counter from the latches. Successive timeouts are L+2 strobes apart, where L is the 16-bit latch value.
- R7: The counter changes only on clocks where `cnt_en` is 1, or on a write to offset 5.
- R8: With `out_en`=1 in one-shot mode, a write to offset 5 drives `pulse_out` to 0, and `pulse_out` returns to 1 after the timeout.
- R9: With `out_en`=1 in periodic mode, `pulse_out` inverts at each timeout. With `out_en`=0, `pulse_out` never changes.
- R10: Offset 4 reads the counter's low byte and a read there produces a `flag_clr` pulse. Offset 5 reads the counter's high byte, offset 7 reads the high latch, and reads of offsets 5, 6 and 7 produce no pulse.
- R11: When a timeout and a clearing access occur in the same cycle, only `flag_set` is driven. The two pulses are never high together.
- R12: When a write to offset 5 coincides with the strobe that would time out, the load takes effect. No `flag_set` is produced.
- R13: Offsets other than 4 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count strobe; the counter steps on clocks where this is high |
| sel | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; only its side effects depend on it |
| wr_data | input | 8 | Write data |
| out_en | input | 1 | Timer drives `pulse_out` |
| free_run | input | 1 | 1 = periodic reload, 0 = one-shot |
| rd_data | output | 8 | Read data for `sel`, combinational |
| pulse_out | output | 1 | Timer-driven pin level |
| flag_set | output | 1 | One-cycle set pulse for the external flag |
| flag_clr | output | 1 | One-cycle clear pulse for the external flag |

## Verification
Two pairs of functions can fall in the same cycle. A timeout can meet a clearing read of offset 4, and a timeout can meet a restart through offset 5. The bench loads a count of 2 and steps it with back-to-back strobes, then places the read or the write on exactly the third strobe. It then judges which pulse appears in the next cycle and what value the counter reads back. The one-shot case is also run for a full 16-bit wrap, and the bench counts `flag_set` pulses to show that a second timeout stays silent.

// File: rtl/itm_pkg.sv
package itm_pkg;
  // register offsets whose meaning the bus side depends on
  localparam int OFF_CNT_LO = 4;
  localparam int OFF_CNT_HI = 5;
  localparam int OFF_LAT_LO = 6;
  localparam int OFF_LAT_HI = 7;

  // decoded bus access for one cycle
  typedef struct packed {
    logic lo_wr;   // low latch write
    logic hi_wr;   // high latch write only
    logic load;    // high byte write that starts the counter
    logic rd_clr;  // low counter read that acknowledges the flag
  } acc_t;
endpackage

// File: rtl/itm_decode.sv
module itm_decode
  import itm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_en,
  input  logic              rd_en,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_LLO = ADDR_W'(OFF_LAT_LO);
  localparam logic [ADDR_W-1:0] A_LHI = ADDR_W'(OFF_LAT_HI);

  always_comb begin
    acc.lo_wr  = wr_en && ((sel == A_CLO) || (sel == A_LLO));
    acc.hi_wr  = wr_en && (sel == A_LHI);
    acc.load   = wr_en && (sel == A_CHI);
    acc.rd_clr = rd_en && (sel == A_CLO);
  end
endmodule

// File: rtl/itm_latch.sv
module itm_latch
  import itm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] lat_lo,
  output logic [DW-1:0] lat_hi
);
  logic [DW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = lat_lo;
    hi_d = lat_hi;
    if (acc.lo_wr)              lo_d = wr_data;
    if (acc.hi_wr || acc.load)  hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_lo <= '1;
      lat_hi <= '1;
    end else begin
      lat_lo <= lo_d;
      lat_hi <= hi_d;
    end
  end
endmodule

// File: rtl/itm_counter.sv
module itm_counter #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          free_run,
  output logic [CW-1:0] cnt_q,
  output logic          expire,
  output logic          fire
);
  logic          pend_q, armed_q;
  logic [CW-1:0] cnt_d;
  logic          pend_d, armed_d;
  logic          step, at_zero;

  assign step    = cnt_en && !load;
  assign at_zero = (cnt_q == '0);
  assign expire  = step && !pend_q && at_zero;
  assign fire    = expire && armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = load_val;
      pend_d  = 1'b0;
      armed_d = 1'b1;
    end else if (step) begin
      if (pend_q) begin
        cnt_d  = reload_val;
        pend_d = 1'b0;
      end else if (at_zero) begin
        cnt_d   = '1;
        pend_d  = free_run;
        armed_d = armed_q && free_run;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/itm_outputs.sv
module itm_outputs (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic fire,
  input  logic load,
  input  logic clr_req,
  input  logic out_en,
  input  logic free_run,
  output logic pulse_out,
  output logic flag_set,
  output logic flag_clr
);
  logic pin_d, set_d, clr_d;

  always_comb begin
    set_d = fire;
    clr_d = clr_req && !fire;
    pin_d = pulse_out;
    if (out_en) begin
      if (load && !free_run)  pin_d = 1'b0;
      else if (expire)        pin_d = free_run ? !pulse_out : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_out <= 1'b1;
      flag_set  <= 1'b0;
      flag_clr  <= 1'b0;
    end else begin
      pulse_out <= pin_d;
      flag_set  <= set_d;
      flag_clr  <= clr_d;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              out_en,
  input  logic              free_run,
  output logic [DW-1:0]     rd_data,
  output logic              pulse_out,
  output logic              flag_set,
  output logic              flag_clr
);
  localparam int CW = 2 * DW;

  acc_t          acc;
  logic [DW-1:0] lat_lo, lat_hi;
  logic [CW-1:0] cnt_q;
  logic          expire, fire;

  itm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .acc(acc)
  );

  itm_latch #(.DW(DW)) u_lat (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr_data(wr_data),
    .lat_lo(lat_lo), .lat_hi(lat_hi)
  );

  itm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load(acc.load),
    .load_val({wr_data, lat_lo}), .reload_val({lat_hi, lat_lo}),
    .free_run(free_run), .cnt_q(cnt_q), .expire(expire), .fire(fire)
  );

  itm_outputs u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .fire(fire),
    .load(acc.load), .clr_req(acc.load || acc.hi_wr || acc.rd_clr),
    .out_en(out_en), .free_run(free_run),
    .pulse_out(pulse_out), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  always_comb begin
    rd_data = '0;
    if (sel == ADDR_W'(OFF_CNT_LO))      rd_data = cnt_q[DW-1:0];
    else if (sel == ADDR_W'(OFF_CNT_HI)) rd_data = cnt_q[CW-1:DW];
    else if (sel == ADDR_W'(OFF_LAT_LO)) rd_data = lat_lo;
    else if (sel == ADDR_W'(OFF_LAT_HI)) rd_data = lat_hi;
  end
endmodule

// File: rtl/itm_checker.sv
module itm_checker
  import itm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  localparam int CW    = 2 * DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [ADDR_W-1:0] sel,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              out_en,
  input logic              free_run,
  input logic              pulse_out,
  input logic              flag_set,
  input logic              flag_clr,
  input logic [CW-1:0]     cnt_q,
  input logic [DW-1:0]     lat_lo,
  input logic [DW-1:0]     lat_hi
);
  logic ld;
  assign ld = wr_en && (sel == ADDR_W'(OFF_CNT_HI));

  a_r2_high_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((sel == ADDR_W'(OFF_CNT_LO)) || (sel == ADDR_W'(OFF_LAT_LO)))) |=> $stable(lat_hi));

  a_r3_latch_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == ADDR_W'(OFF_LAT_HI))) |=> (flag_clr || flag_set));

  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == {$past(wr_data), $past(lat_lo)}) && flag_clr);

  a_r5_timeout_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> (cnt_q == '1));

  a_r7_counter_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ld) |=> $stable(cnt_q));

  a_r8_oneshot_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && out_en && !free_run) |=> !pulse_out);

  a_r9_pin_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(pulse_out));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_set && flag_clr));

  a_r12_load_beats_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !flag_set);
endmodule

bind interval_timer itm_checker #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sel(sel), .wr_en(wr_en),
  .wr_data(wr_data), .out_en(out_en), .free_run(free_run),
  .pulse_out(pulse_out), .flag_set(flag_set), .flag_clr(flag_clr),
  .cnt_q(cnt_q), .lat_lo(lat_lo), .lat_hi(lat_hi)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n, cnt_en, wr_en, rd_en, out_en, free_run;
  logic [3:0] sel;
  logic [7:0] wr_data, rd_data;
  logic       pulse_out, flag_set, flag_clr;

  always #2 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .out_en(out_en), .free_run(free_run),
    .rd_data(rd_data), .pulse_out(pulse_out), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  localparam int S_RD = 0, S_SET = 1, S_CLR = 2, S_PIN = 3, S_VAL = 4;

  typedef struct {
    string       req;
    int          sig;
    logic [31:0] act;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  task automatic expect_sig(input string req, input int sig, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sig = sig; it.act = '0; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sig = S_VAL; it.act = act; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations half a cycle after the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t       it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.sig)
        S_RD:    got = 32'(rd_data);
        S_SET:   got = 32'(flag_set);
        S_CLR:   got = 32'(flag_clr);
        S_PIN:   got = 32'(pulse_out);
        default: got = it.act;
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_err++;
        $display("FAIL %s: sig %0d got %0h expected %0h", it.req, it.sig, got, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    sel = s; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] exp, input string req);
    sel = s; rd_en = 1'b1;
    expect_sig(req, S_RD, 32'(exp));
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n_set;
    logic tog;
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    sel = '0; wr_data = '0; out_en = 1'b0; free_run = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    expect_sig("R1", S_PIN, 1);
    expect_sig("R1", S_SET, 0);
    expect_sig("R1", S_CLR, 0);
    rd(4'd6, 8'hFF, "R1");
    rd(4'd7, 8'hFF, "R1");

    // R2 low latch writes through both offsets
    wr(4'd4, 8'h34);
    rd(4'd6, 8'h34, "R2");
    rd(4'd7, 8'hFF, "R2");
    wr(4'd6, 8'h12);
    rd(4'd6, 8'h12, "R2");

    // R13 unused offset
    wr(4'd2, 8'h55);
    expect_sig("R13", S_CLR, 0);
    rd(4'd6, 8'h12, "R13");
    rd(4'd7, 8'hFF, "R13");
    rd(4'd2, 8'h00, "R13");

    // R3 high latch write
    wr(4'd7, 8'hAB);
    expect_sig("R3", S_CLR, 1);
    rd(4'd7, 8'hAB, "R3");
    rd(4'd5, 8'hFF, "R3");
    expect_sig("R10", S_CLR, 0);
    rd(4'd4, 8'hFF, "R10");
    expect_sig("R10", S_CLR, 1);
    rd(4'd6, 8'h12, "R10");
    expect_sig("R10", S_CLR, 0);

    // R4 load through offset 5
    wr(4'd5, 8'h02);
    expect_sig("R4", S_CLR, 1);
    rd(4'd4, 8'h12, "R4");
    rd(4'd5, 8'h02, "R4");
    rd(4'd7, 8'h02, "R4");

    // R7 counter steps only on strobes
    repeat (5) cyc();
    rd(4'd4, 8'h12, "R7");
    for (int i = 0; i < 6; i++) begin
      cnt_en = (i % 2 == 0);
      cyc();
    end
    cnt_en = 1'b0;
    rd(4'd4, 8'h0F, "R7");

    // R9 pin untouched with output disabled (one-shot load)
    wr(4'd5, 8'h00);
    expect_sig("R9", S_PIN, 1);

    // R5 / R8 one-shot with output enabled, load of 3
    out_en = 1'b1; free_run = 1'b0;
    wr(4'd6, 8'h03);
    wr(4'd5, 8'h00);
    expect_sig("R8", S_PIN, 0);
    cnt_en = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      cyc();
      expect_sig("R5", S_SET, (i == 4) ? 1 : 0);
      expect_sig("R8", S_PIN, (i == 4) ? 1 : 0);
    end
    cyc();
    cnt_en = 1'b0;
    expect_sig("R5", S_SET, 0);
    rd(4'd4, 8'hFE, "R5");
    rd(4'd5, 8'hFF, "R5");

    // R5 full wrap: no second flag
    n_set = 0;
    cnt_en = 1'b1;
    repeat (65600) begin
      cyc();
      if (flag_set) n_set++;
    end
    cnt_en = 1'b0;
    expect_val("R5", 32'(n_set), 0);
    expect_sig("R8", S_PIN, 1);
    rd(4'd4, 8'hBE, "R5");
    rd(4'd5, 8'hFF, "R5");

    // R6 / R9 periodic, latch 2, period 4
    free_run = 1'b1;
    wr(4'd6, 8'h02);
    wr(4'd5, 8'h00);
    expect_sig("R9", S_PIN, 1);
    tog = 1'b1;
    cnt_en = 1'b1;
    for (int i = 1; i <= 11; i++) begin
      cyc();
      if (i % 4 == 3) tog = ~tog;
      expect_sig("R6", S_SET, (i % 4 == 3) ? 1 : 0);
      expect_sig("R9", S_PIN, 32'(tog));
    end
    out_en = 1'b0;
    for (int i = 12; i <= 19; i++) begin
      cyc();
      expect_sig("R6", S_SET, (i % 4 == 3) ? 1 : 0);
      expect_sig("R9", S_PIN, 0);
    end
    cnt_en = 1'b0;

    // R11 timeout meets low counter read
    wr(4'd5, 8'h00);
    cnt_en = 1'b1;
    cyc();
    cyc();
    rd(4'd4, 8'h00, "R11");
    cnt_en = 1'b0;
    expect_sig("R11", S_SET, 1);
    expect_sig("R11", S_CLR, 0);
    rd(4'd4, 8'hFF, "R11");
    expect_sig("R11", S_CLR, 1);

    // R12 timeout meets restart
    wr(4'd5, 8'h00);
    cnt_en = 1'b1;
    cyc();
    cyc();
    wr(4'd5, 8'h01);
    cnt_en = 1'b0;
    expect_sig("R12", S_SET, 0);
    expect_sig("R12", S_CLR, 1);
    rd(4'd4, 8'h02, "R12");
    rd(4'd5, 8'h01, "R12");

    cyc();
    cyc();
    done = 1'b1;
    finish_run();
  end
endmodule